// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block converts a column offset and a page (row) number into the ordered series of single-byte address cycles that a NAND flash bus engine puts on the wire, one cycle at a time. A controller pulses `start_i` with the column, the page, a page-size code and a row-width mask. The sequencer then emits one byte per cycle on `addr_byte_o`, qualified by a one-cycle `addr_stb_o`. Before it emits the next byte it waits for the bus engine to acknowledge the previous one on `op_done_i`.

The column phase has one or two bytes, depending on the page-size code. The row phase sends the page number least significant byte first. The number of row bytes is decided at run time: the latched mask is shifted right one byte per row cycle, and the phase ends once the shifted mask is zero. Either phase can be skipped through its valid flag, for example when an erase carries no column. Once the final acknowledge arrives, `done_o` pulses for one cycle.

Top module: `nand_addr_seq`

## Requirements
- R1: When the column valid flag is set at start, the first strobed byte is column bits 7:0.
- R2: With page-size code 2'b01 (2K pages), a second column byte follows, holding column bits 11:8 in its low four bits with zeros above.
- R3: With page-size code 2'b10 or 2'b11 (4K pages), the second column byte holds column bits 12:8 in its low five bits with zeros above. With code 2'b00 (small pages), only one column byte is sent.
- R4: Row bytes carry the page number eight bits at a time, least significant byte first.
- R5: After each row byte the mask is shifted right by eight. Row bytes continue while the shifted mask is non-zero, so a mask of zero still gives exactly one row byte.
- R6: No byte is strobed until the bus engine has acknowledged the previous one. An acknowledge that arrives while no byte is outstanding has no effect on the ports.
- R7: A clear column valid flag skips every column byte. A clear page valid flag skips every row byte.
- R8: `addr_stb_o` and `done_o` are each one-cycle pulses and never coincide. Exactly one `done_o` pulse follows each accepted start.
- R9: If both valid flags are clear at start, `done_o` rises in the cycle after start and no byte is strobed.
- R10: All inputs are captured at start, so later changes have no effect. A start that arrives before the sequence has finished is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| col_vld_i | input | 1 | Column phase requested |
| col_i | input | COL_W | Column offset |
| page_vld_i | input | 1 | Row phase requested |
| page_i | input | ROW_W | Page (row) number |
| pgsz_i | input | 2 | Page-size code: 00 small, 01 2K, 1x 4K |
| page_mask_i | input | ROW_W | Row-width mask that sets the number of row bytes |
| op_done_i | input | 1 | Bus engine acknowledge of the last strobed byte |
| addr_stb_o | output | 1 | Address byte strobe, one cycle |
| addr_byte_o | output | 8 | Address byte, valid with the strobe |
| done_o | output | 1 | Sequence complete, one cycle |

## Verification
Two events can meet in the same clock cycle: a new start can arrive in the cycle `done_o` is high or while a byte is still outstanding, and a bus acknowledge can arrive while the sequencer is idle. The bench provokes both. It pulses start in the middle of a sequence whose acknowledges are held back, and it sends an acknowledge when no cycle is in flight. In each case the outcome is judged only at the ports: the strobed byte list must match the first request exactly, and each request must produce exactly one done pulse.

// File: rtl/nas_pkg.sv
package nas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COL0,
    ST_COL1,
    ST_ROW,
    ST_WAIT,
    ST_DONE
  } nas_state_e;

  // which byte source the current/last strobe came from
  typedef enum logic [1:0] {
    SEL_COL0,
    SEL_COL1,
    SEL_ROW
  } nas_sel_e;

  localparam int unsigned ADDR_BYTE_W = 8;

endpackage

// File: rtl/nas_addr_regs.sv
module nas_addr_regs
  import nas_pkg::*;
#(
  parameter int unsigned COL_W = 13,
  parameter int unsigned ROW_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   shift,
  input  logic                   col_vld_i,
  input  logic [COL_W-1:0]       col_i,
  input  logic                   page_vld_i,
  input  logic [ROW_W-1:0]       page_i,
  input  logic [1:0]             pgsz_i,
  input  logic [ROW_W-1:0]       mask_i,
  output logic                   col_vld,
  output logic                   page_vld,
  output logic                   two_col,
  output logic                   mask_more,
  output logic [ADDR_BYTE_W-1:0] col_lo,
  output logic [ADDR_BYTE_W-1:0] col_hi,
  output logic [ADDR_BYTE_W-1:0] row_byte
);

  localparam int unsigned HI2K_W = 4;
  localparam int unsigned HI4K_W = 5;
  localparam int unsigned HI_LSB = ADDR_BYTE_W;

  logic             col_vld_q, page_vld_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] page_q, mask_q;
  logic [1:0]       pgsz_q;

  // captured request; the row part shifts one byte per row cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_vld_q  <= 1'b0;
      page_vld_q <= 1'b0;
      col_q      <= '0;
      page_q     <= '0;
      mask_q     <= '0;
      pgsz_q     <= '0;
    end else if (load) begin
      col_vld_q  <= col_vld_i;
      page_vld_q <= page_vld_i;
      col_q      <= col_i;
      page_q     <= page_i;
      mask_q     <= mask_i;
      pgsz_q     <= pgsz_i;
    end else if (shift) begin
      page_q     <= page_q >> ADDR_BYTE_W;
      mask_q     <= mask_q >> ADDR_BYTE_W;
    end
  end

  assign col_vld   = col_vld_q;
  assign page_vld  = page_vld_q;
  assign two_col   = |pgsz_q;
  assign mask_more = |mask_q;
  assign col_lo    = col_q[ADDR_BYTE_W-1:0];
  assign row_byte  = ADDR_BYTE_W'(page_q);

  always_comb begin
    if (pgsz_q[1]) begin
      col_hi = ADDR_BYTE_W'(col_q[HI_LSB+HI4K_W-1:HI_LSB]);
    end else begin
      col_hi = ADDR_BYTE_W'(col_q[HI_LSB+HI2K_W-1:HI_LSB]);
    end
  end

endmodule

// File: rtl/nas_fsm.sv
module nas_fsm
  import nas_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     col_vld_i,
  input  logic     page_vld_i,
  input  logic     op_done_i,
  input  logic     col_vld,
  input  logic     page_vld,
  input  logic     two_col,
  input  logic     mask_more,
  output logic     load,
  output logic     shift,
  output logic     stb,
  output nas_sel_e sel,
  output logic     done
);

  nas_state_e state_q, state_d;
  nas_sel_e   last_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    stb     = 1'b0;
    sel     = last_q;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load = 1'b1;
          if (col_vld_i)       state_d = ST_COL0;
          else if (page_vld_i) state_d = ST_ROW;
          else                 state_d = ST_DONE;
        end
      end
      ST_COL0: begin
        stb     = 1'b1;
        sel     = SEL_COL0;
        state_d = ST_WAIT;
      end
      ST_COL1: begin
        stb     = 1'b1;
        sel     = SEL_COL1;
        state_d = ST_WAIT;
      end
      ST_ROW: begin
        stb     = 1'b1;
        sel     = SEL_ROW;
        shift   = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (op_done_i) begin
          unique case (last_q)
            SEL_COL0: state_d = two_col ? ST_COL1 : (page_vld ? ST_ROW : ST_DONE);
            SEL_COL1: state_d = page_vld ? ST_ROW : ST_DONE;
            default:  state_d = mask_more ? ST_ROW : ST_DONE;
          endcase
        end
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= SEL_COL0;
    end else begin
      state_q <= state_d;
      if (stb) last_q <= sel;
    end
  end

  // column valid is consumed at start; latched copy kept for the port view
  logic unused_col_vld;
  assign unused_col_vld = col_vld;

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int unsigned COL_W = 13,
  parameter int unsigned ROW_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             col_vld_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             page_vld_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic [1:0]       pgsz_i,
  input  logic [ROW_W-1:0] page_mask_i,
  input  logic             op_done_i,
  output logic             addr_stb_o,
  output logic [7:0]       addr_byte_o,
  output logic             done_o
);

  logic     load, shift, stb, done;
  logic     col_vld, page_vld, two_col, mask_more;
  logic [ADDR_BYTE_W-1:0] col_lo, col_hi, row_byte;
  nas_sel_e sel;

  nas_addr_regs #(
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .shift      (shift),
    .col_vld_i  (col_vld_i),
    .col_i      (col_i),
    .page_vld_i (page_vld_i),
    .page_i     (page_i),
    .pgsz_i     (pgsz_i),
    .mask_i     (page_mask_i),
    .col_vld    (col_vld),
    .page_vld   (page_vld),
    .two_col    (two_col),
    .mask_more  (mask_more),
    .col_lo     (col_lo),
    .col_hi     (col_hi),
    .row_byte   (row_byte)
  );

  nas_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .col_vld_i  (col_vld_i),
    .page_vld_i (page_vld_i),
    .op_done_i  (op_done_i),
    .col_vld    (col_vld),
    .page_vld   (page_vld),
    .two_col    (two_col),
    .mask_more  (mask_more),
    .load       (load),
    .shift      (shift),
    .stb        (stb),
    .sel        (sel),
    .done       (done)
  );

  always_comb begin
    unique case (sel)
      SEL_COL0: addr_byte_o = col_lo;
      SEL_COL1: addr_byte_o = col_hi;
      default:  addr_byte_o = row_byte;
    endcase
  end

  assign addr_stb_o = stb;
  assign done_o     = done;

endmodule

// File: rtl/nas_chk.sv
module nas_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic col_vld_i,
  input logic page_vld_i,
  input logic op_done_i,
  input logic addr_stb_o,
  input logic done_o
);

  logic pend_q;    // a strobed byte awaits its acknowledge
  logic active_q;  // a start has been accepted and done not yet seen

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (addr_stb_o)     pend_q <= 1'b1;
      else if (op_done_i) pend_q <= 1'b0;
      if (done_o)                    active_q <= 1'b0;
      else if (start_i && !active_q) active_q <= 1'b1;
    end
  end

  p_ack_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_o |-> !pend_q);

  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_o |=> !addr_stb_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb_o && done_o));

  p_empty_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_q && !col_vld_i && !page_vld_i) |=> (done_o && !addr_stb_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!addr_stb_o && !done_o));

endmodule

bind nand_addr_seq nas_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .col_vld_i  (col_vld_i),
  .page_vld_i (page_vld_i),
  .op_done_i  (op_done_i),
  .addr_stb_o (addr_stb_o),
  .done_o     (done_o)
);

// File: tb/sim_nand_addr_seq.sv
`timescale 1ns/1ps
module sim_nand_addr_seq;

  typedef struct packed {
    logic        cv;
    logic [12:0] col;
    logic        pv;
    logic [23:0] page;
    logic [1:0]  sz;
    logic [23:0] mask;
    logic [3:0]  lat;
    logic [2:0]  n;
    logic [39:0] exp;   // byte k at bits 8k+7:8k
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b1, 13'h0A5C, 1'b1, 24'h012345, 2'd1, 24'h00FFFF, 4'd1, 3'd4, 40'h00_23_45_0A_5C},
    '{1'b1, 13'h1F3E, 1'b1, 24'h0ABCDE, 2'd2, 24'h03FFFF, 4'd2, 3'd5, 40'h0A_BC_DE_1F_3E},
    '{1'b1, 13'h1FFF, 1'b0, 24'h555555, 2'd2, 24'hFFFFFF, 4'd3, 3'd2, 40'h00_00_00_1F_FF},
    '{1'b1, 13'h1FFF, 1'b1, 24'h000077, 2'd1, 24'h000000, 4'd1, 3'd3, 40'h00_00_77_0F_FF},
    '{1'b1, 13'h1234, 1'b1, 24'hFEDCBA, 2'd0, 24'hFFFFFF, 4'd4, 3'd4, 40'h00_FE_DC_BA_34},
    '{1'b0, 13'h1111, 1'b1, 24'h000102, 2'd1, 24'h0000FF, 4'd2, 3'd1, 40'h00_00_00_00_02},
    '{1'b1, 13'h1ABC, 1'b0, 24'h000000, 2'd3, 24'h000000, 4'd1, 3'd2, 40'h00_00_00_1A_BC},
    '{1'b0, 13'h0000, 1'b1, 24'hAABBCC, 2'd0, 24'h000100, 4'd3, 3'd2, 40'h00_00_00_BB_CC}
  };

  logic        clk, rst_n, start_i, col_vld_i, page_vld_i, op_done_i;
  logic [12:0] col_i;
  logic [23:0] page_i, page_mask_i;
  logic [1:0]  pgsz_i;
  logic        addr_stb_o, done_o;
  logic [7:0]  addr_byte_o;

  int n_total, n_fail;
  int ncap, ndone, pend, cur_lat;
  logic stray;
  logic [7:0] cap [8];

  nand_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_vld_i(col_vld_i),
    .col_i(col_i), .page_vld_i(page_vld_i), .page_i(page_i), .pgsz_i(pgsz_i),
    .page_mask_i(page_mask_i), .op_done_i(op_done_i), .addr_stb_o(addr_stb_o),
    .addr_byte_o(addr_byte_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bus engine model: acknowledges each strobe after cur_lat cycles
  initial begin
    op_done_i = 1'b0;
    pend = 0; ncap = 0; ndone = 0; stray = 1'b0;
    forever begin
      @(negedge clk);
      op_done_i = 1'b0;
      if (stray) begin op_done_i = 1'b1; stray = 1'b0; end
      if (pend > 0) begin pend--; if (pend == 0) op_done_i = 1'b1; end
      if (addr_stb_o) begin
        if (ncap < 8) cap[ncap] = addr_byte_o;
        ncap++;
        pend = cur_lat;
      end
      if (done_o) ndone++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 300 && ndone == 0; k++) tick();
  endtask

  function automatic string byte_tag(input vec_t v, input int i);
    if (v.cv && i == 0) return "R1 column low byte";
    if (v.cv && i == 1 && v.sz != 2'd0) return (v.sz == 2'd1) ? "R2 2K column high" : "R3 4K column high";
    return "R4 row byte";
  endfunction

  task automatic issue(input vec_t v);
    ncap = 0; ndone = 0; cur_lat = int'(v.lat);
    col_vld_i = v.cv; col_i = v.col; page_vld_i = v.pv; page_i = v.page;
    pgsz_i = v.sz; page_mask_i = v.mask; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    // scramble inputs: captured copy must be used (R10)
    col_vld_i = ~v.cv; col_i = ~v.col; page_vld_i = ~v.pv; page_i = ~v.page;
    pgsz_i = ~v.sz; page_mask_i = ~v.mask;
  endtask

  task automatic check_vec(input vec_t v);
    chk("R5/R7 byte count", ncap, int'(v.n));
    for (int i = 0; i < int'(v.n) && i < 8; i++)
      chk(byte_tag(v, i), cap[i], v.exp[i*8 +: 8]);
    chk("R8 one done pulse", ndone, 1);
  endtask

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; col_vld_i = 1'b0; page_vld_i = 1'b0;
    col_i = '0; page_i = '0; pgsz_i = '0; page_mask_i = '0; cur_lat = 1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("reset strobe low", addr_stb_o, 0);
    chk("reset done low", done_o, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(VT[i]);
      wait_done();
      repeat (4) tick();
      check_vec(VT[i]);
    end

    // R9: nothing to send
    ncap = 0; ndone = 0;
    col_vld_i = 1'b0; page_vld_i = 1'b0; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk("R9 done in cycle after start", done_o, 1);
    tick();
    chk("R8 done lasts one cycle", done_o, 0);
    repeat (4) tick();
    chk("R9 no bytes strobed", ncap, 0);

    // R6: stray acknowledge while idle
    ncap = 0; ndone = 0; stray = 1'b1;
    repeat (6) tick();
    chk("R6 stray ack no strobe", ncap, 0);
    chk("R6 stray ack no done", ndone, 0);

    // R6: strobe held back until acknowledge
    issue(vec_t'{1'b1, 13'h0A5C, 1'b1, 24'h012345, 2'd1, 24'h00FFFF, 4'd15, 3'd4, 40'h00_23_45_0A_5C});
    for (int k = 0; k < 20 && ncap == 0; k++) tick();
    repeat (10) tick();
    chk("R6 no second byte before ack", ncap, 1);
    wait_done();
    repeat (4) tick();
    check_vec(vec_t'{1'b1, 13'h0A5C, 1'b1, 24'h012345, 2'd1, 24'h00FFFF, 4'd15, 3'd4, 40'h00_23_45_0A_5C});

    // R10: start while busy is ignored
    issue(VT[1]);
    cur_lat = 8;
    repeat (3) tick();
    col_vld_i = 1'b0; page_vld_i = 1'b1; page_i = 24'h999999; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    wait_done();
    repeat (12) tick();
    chk("R10 busy start ignored count", ncap, 5);
    chk("R10 busy start ignored done", ndone, 1);
    chk("R10 first byte kept", cap[0], 8'h3E);
    chk("R10 last byte kept", cap[4], 8'h0A);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule